// File: doc/BRIEF.md
# Tunable Colour Subcarrier Oscillator

This block produces the colour subcarrier phase for a composite or separated luma/chroma video encoder. It runs from the video clock and keeps a 40-bit phase accumulator. The low 32 bits of the accumulator are fraction. The top 8 bits form an index into a sine table. Each clock the accumulator advances by a step. That step is the nominal increment for the reference subcarrier, computed as subcarrier frequency × 2^40 / video clock frequency. For example, a 3.579545 MHz subcarrier on a 107.38635 MHz video clock gives 36650387593.

Three run-time controls trim the step so that the subcarrier can be tuned until dot crawl disappears. A 5-bit amount is shifted left by a 5-bit exponent. A direction flag then chooses whether the result is added to or subtracted from the nominal increment. The block also holds the sine table and returns a registered sine and cosine for the current phase. The modulator that consumes these values sits outside this block.

Top module: `chroma_subcarrier_nco`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, `phase_idx`, `sin_out`, `cos_out` and the internal step register are all zero after that edge.
- R2: With `tune_rev` = 0, the step equals `base_inc + (tune_add << tune_mul)` modulo 2^40.
- R3: With `tune_rev` = 1, the step equals `base_inc - (tune_add << tune_mul)` modulo 2^40, including when the result wraps below zero.
- R4: `tune_mul` acts as a left shift of `tune_add` over its full range 0 to 31.
- R5: The step is registered. Control values sampled at edge k move the accumulator first at edge k+1. The step taken at edge k still uses the earlier value.
- R6: At each edge out of reset, `phase_acc` becomes its previous value plus the registered step, modulo 2^40. After reset is released with constant controls, `phase_acc` equals (k−1)·step after k edges.
- R7: `phase_idx` equals bits 39..32 of `phase_acc`.
- R8: `sin_out` is a signed 8-bit value. One clock after `phase_idx` shows index i, it equals round(127·sin(2πi/256)), with halves rounded away from zero.
- R9: `cos_out` is read from the same table as `sin_out`, one clock after index i, at address (i+64) mod 256.
- R10: With `tune_add` = 0, the step equals `base_inc` whatever the values of `tune_mul` and `tune_rev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| base_inc | input | 40 | Nominal phase increment |
| tune_add | input | 5 | Trim amount, 0 to 31 |
| tune_mul | input | 5 | Trim left-shift exponent, 0 to 31 |
| tune_rev | input | 1 | 1 subtracts the trim, 0 adds it |
| phase_acc | output | 40 | Registered phase accumulator |
| phase_idx | output | 8 | Table index, top bits of the accumulator |
| sin_out | output | 8 | Registered signed sine of the index |
| cos_out | output | 8 | Registered signed cosine of the index |

## Verification
The properties assume that `rst` is high from time zero and stays high until the first edges have cleared every register. They also assume that every control input holds a defined value at each rising edge. The accumulator property treats any 40-bit step as legal, so the controls may change on any cycle. The bench meets these assumptions by driving all inputs on falling edges only and by holding reset for two edges before each scenario.

// File: rtl/chroma_nco_pkg.sv
`timescale 1ns/1ps
package chroma_nco_pkg;
  // Default geometry of the oscillator
  localparam int PHASE_W_DEF = 40;
  localparam int IDX_W_DEF   = 8;
  localparam int AMP_W_DEF   = 8;
  localparam int TUNE_W_DEF  = 5;
endpackage

// File: rtl/chroma_step_trim.sv
`timescale 1ns/1ps
// Registers the tuned phase step: base +/- (amount << exponent), mod 2^PHASE_W.
module chroma_step_trim #(
  parameter int PHASE_W = chroma_nco_pkg::PHASE_W_DEF,
  parameter int TUNE_W  = chroma_nco_pkg::TUNE_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] base_inc,
  input  logic [TUNE_W-1:0]  tune_add,
  input  logic [TUNE_W-1:0]  tune_mul,
  input  logic               tune_rev,
  output logic [PHASE_W-1:0] step_q
);
  localparam int PAD_W = PHASE_W - TUNE_W;

  logic [PHASE_W-1:0] offset;
  logic [PHASE_W-1:0] step_d;

  always_comb begin
    offset = {{PAD_W{1'b0}}, tune_add} << tune_mul;
    step_d = tune_rev ? (base_inc - offset) : (base_inc + offset);
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= '0;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/chroma_phase_accum.sv
`timescale 1ns/1ps
// Wrapping phase accumulator; index taken from the top bits.
module chroma_phase_accum #(
  parameter int PHASE_W = chroma_nco_pkg::PHASE_W_DEF,
  parameter int IDX_W   = chroma_nco_pkg::IDX_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] acc_q,
  output logic [IDX_W-1:0]   idx
);
  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_q + step;
  end

  assign idx = acc_q[PHASE_W-1 -: IDX_W];
endmodule

// File: rtl/chroma_sincos_rom.sv
`timescale 1ns/1ps
// Single sine table with two registered read ports; cosine is a quarter turn ahead.
module chroma_sincos_rom #(
  parameter int IDX_W = chroma_nco_pkg::IDX_W_DEF,
  parameter int AMP_W = chroma_nco_pkg::AMP_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IDX_W-1:0]        idx,
  output logic signed [AMP_W-1:0] sin_q,
  output logic signed [AMP_W-1:0] cos_q
);
  localparam int DEPTH   = 1 << IDX_W;
  localparam int QUARTER = DEPTH / 4;
  localparam int PEAK    = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] table_mem [DEPTH];
  logic [IDX_W-1:0]        cos_addr;

  function automatic logic signed [AMP_W-1:0] sine_at(input int i);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(i) / real'(DEPTH);
    v   = real'(PEAK) * $sin(ang);
    if (v >= 0.0) sine_at = AMP_W'($rtoi(v + 0.5));
    else          sine_at = AMP_W'($rtoi(v - 0.5));
  endfunction

  initial begin
    for (int i = 0; i < DEPTH; i++) table_mem[i] = sine_at(i);
  end

  assign cos_addr = idx + IDX_W'(QUARTER);

  always_ff @(posedge clk) begin
    if (rst) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= table_mem[idx];
      cos_q <= table_mem[cos_addr];
    end
  end
endmodule

// File: rtl/chroma_subcarrier_nco.sv
`timescale 1ns/1ps
// Top: tuned step register, phase accumulator, sine/cosine lookup.
module chroma_subcarrier_nco #(
  parameter int PHASE_W = chroma_nco_pkg::PHASE_W_DEF,
  parameter int IDX_W   = chroma_nco_pkg::IDX_W_DEF,
  parameter int AMP_W   = chroma_nco_pkg::AMP_W_DEF,
  parameter int TUNE_W  = chroma_nco_pkg::TUNE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      base_inc,
  input  logic [TUNE_W-1:0]       tune_add,
  input  logic [TUNE_W-1:0]       tune_mul,
  input  logic                    tune_rev,
  output logic [PHASE_W-1:0]      phase_acc,
  output logic [IDX_W-1:0]        phase_idx,
  output logic signed [AMP_W-1:0] sin_out,
  output logic signed [AMP_W-1:0] cos_out
);
  logic [PHASE_W-1:0] step_q;

  chroma_step_trim #(.PHASE_W(PHASE_W), .TUNE_W(TUNE_W)) trim_i (
    .clk(clk), .rst(rst), .base_inc(base_inc), .tune_add(tune_add),
    .tune_mul(tune_mul), .tune_rev(tune_rev), .step_q(step_q)
  );

  chroma_phase_accum #(.PHASE_W(PHASE_W), .IDX_W(IDX_W)) accum_i (
    .clk(clk), .rst(rst), .step(step_q), .acc_q(phase_acc), .idx(phase_idx)
  );

  chroma_sincos_rom #(.IDX_W(IDX_W), .AMP_W(AMP_W)) rom_i (
    .clk(clk), .rst(rst), .idx(phase_idx), .sin_q(sin_out), .cos_q(cos_out)
  );
endmodule

// File: rtl/chroma_nco_checker.sv
`timescale 1ns/1ps
module chroma_nco_checker #(
  parameter int PHASE_W = 40,
  parameter int IDX_W   = 8,
  parameter int AMP_W   = 8,
  parameter int TUNE_W  = 5
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PHASE_W-1:0]      base_inc,
  input logic [TUNE_W-1:0]       tune_add,
  input logic [PHASE_W-1:0]      step,
  input logic [PHASE_W-1:0]      phase_acc,
  input logic [IDX_W-1:0]        phase_idx,
  input logic signed [AMP_W-1:0] sin_out,
  input logic signed [AMP_W-1:0] cos_out
);
  localparam int QUARTER = (1 << IDX_W) / 4;
  localparam logic signed [AMP_W-1:0] PEAK = AMP_W'((1 << (AMP_W - 1)) - 1);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (phase_acc == '0 && sin_out == '0 && cos_out == '0 && step == '0));

  assert_accumulates_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_acc == PHASE_W'($past(phase_acc) + $past(step)));

  assert_zero_trim_keeps_base_R10: assert property (@(posedge clk) disable iff (rst)
    (tune_add == '0) |=> step == $past(base_inc));

  assert_trim_moves_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tune_add != '0) |=> step != $past(base_inc));

  assert_sine_peak_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_idx == IDX_W'(QUARTER)) |=> sin_out == PEAK);

  assert_cosine_peak_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_idx == '0) |=> cos_out == PEAK);
endmodule

bind chroma_subcarrier_nco chroma_nco_checker #(
  .PHASE_W(PHASE_W), .IDX_W(IDX_W), .AMP_W(AMP_W), .TUNE_W(TUNE_W)
) checker_i (
  .clk(clk), .rst(rst), .base_inc(base_inc), .tune_add(tune_add),
  .step(step_q), .phase_acc(phase_acc), .phase_idx(phase_idx),
  .sin_out(sin_out), .cos_out(cos_out)
);

// File: tb/chroma_subcarrier_nco_tb.sv
`timescale 1ns/1ps
module chroma_subcarrier_nco_tb_top;
  localparam logic [39:0] NOMINAL = 40'd36650387593;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] base_inc = '0;
  logic [4:0]  tune_add = '0;
  logic [4:0]  tune_mul = '0;
  logic        tune_rev = 1'b0;
  logic [39:0] phase_acc;
  logic [7:0]  phase_idx;
  logic signed [7:0] sin_out;
  logic signed [7:0] cos_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  chroma_subcarrier_nco dut_i (
    .clk(clk), .rst(rst), .base_inc(base_inc), .tune_add(tune_add),
    .tune_mul(tune_mul), .tune_rev(tune_rev), .phase_acc(phase_acc),
    .phase_idx(phase_idx), .sin_out(sin_out), .cos_out(cos_out)
  );

  function automatic logic [39:0] want_step(input logic [39:0] b, input logic [4:0] a,
                                            input logic [4:0] m, input logic r);
    logic [63:0] off;
    logic [63:0] s;
    off = 64'(a) << m;
    s = r ? (64'(b) - off) : (64'(b) + off);
    return s[39:0];
  endfunction

  function automatic logic signed [7:0] want_sine(input int i);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * real'(i) / 256.0);
    if (v >= 0.0) return 8'($rtoi(v + 0.5));
    return 8'($rtoi(v - 0.5));
  endfunction

  task automatic check_val(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic start_run(input logic [39:0] b, input logic [4:0] a,
                           input logic [4:0] m, input logic r);
    @(negedge clk);
    rst = 1'b1;
    base_inc = b; tune_add = a; tune_mul = m; tune_rev = r;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: reset after activity clears all state
  task automatic test_reset();
    start_run(40'd98765432101, 5'd3, 5'd4, 1'b0);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_val("R1", "phase_acc", 64'(phase_acc), 64'd0);
    check_val("R1", "phase_idx", 64'(phase_idx), 64'd0);
    check_val("R1", "sin_out", 64'(sin_out), 64'd0);
    check_val("R1", "cos_out", 64'(cos_out), 64'd0);
  endtask

  // R2/R3/R4/R6/R7/R10: accumulate for n edges and compare with (n-1)*step
  task automatic test_accum(input string req, input logic [39:0] b, input logic [4:0] a,
                            input logic [4:0] m, input logic r, input int n);
    logic [39:0] st;
    logic [63:0] prod;
    start_run(b, a, m, r);
    repeat (n) @(negedge clk);
    st = want_step(b, a, m, r);
    prod = 64'(n - 1) * 64'(st);
    check_val(req, "phase_acc", 64'(phase_acc), 64'(prod[39:0]));
    check_val("R7", "phase_idx", 64'(phase_idx), 64'(prod[39:32]));
  endtask

  // R5: one-clock latency of a control change
  task automatic test_latency();
    logic [39:0] a0;
    logic [39:0] e1;
    logic [39:0] e2;
    e1 = 40'h01_0000_0000;
    e2 = want_step(e1, 5'd7, 5'd10, 1'b0);
    start_run(e1, 5'd0, 5'd0, 1'b0);
    repeat (5) @(negedge clk);
    a0 = phase_acc;
    tune_add = 5'd7; tune_mul = 5'd10;
    @(negedge clk);
    check_val("R5", "first step after change", 64'(phase_acc), 64'(40'(a0 + e1)));
    @(negedge clk);
    check_val("R5", "second step after change", 64'(phase_acc), 64'(40'(a0 + e1 + e2)));
  endtask

  // R8/R9: table outputs one clock behind the index
  task automatic test_sincos(input logic [39:0] b);
    logic [7:0] prev;
    start_run(b, 5'd0, 5'd0, 1'b0);
    @(negedge clk);
    prev = phase_idx;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      check_val("R8", "sin_out", 64'(sin_out), 64'(want_sine(int'(prev))));
      check_val("R9", "cos_out", 64'(cos_out), 64'(want_sine((int'(prev) + 64) % 256)));
      prev = phase_idx;
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    test_reset();
    test_accum("R2", NOMINAL, 5'd5, 5'd0, 1'b0, 1000);
    test_accum("R4", NOMINAL, 5'd3, 5'd20, 1'b0, 777);
    test_accum("R4", NOMINAL, 5'd31, 5'd31, 1'b0, 50);
    test_accum("R3", NOMINAL, 5'd31, 5'd31, 1'b1, 300);
    test_accum("R3", NOMINAL, 5'd9, 5'd12, 1'b1, 400);
    test_accum("R6", 40'd0, 5'd1, 5'd0, 1'b1, 100);
    test_accum("R10", NOMINAL, 5'd0, 5'd17, 1'b1, 500);
    test_accum("R6", 40'hFF_FFFF_FFF0, 5'd0, 5'd0, 1'b0, 3);
    test_latency();
    test_sincos(40'h01_0000_0000);
    test_sincos(40'h25_0000_007B);
    finish_up();
  end
endmodule